// File: doc/BRIEF.md
# Two-Dimensional Frame-Indexed DMA Engine

This block is a single DMA channel that copies a block of data organised as frames of elements. For each element it issues a read from the current source address, keeps the returned word, and then writes that word to the current destination address. It does not start the next element until that write has been acknowledged. The element count sets the size of the first frame. Every later frame takes its size from a reload register, and the frame count sets how many frames there are.

The source address and the destination address each follow their own stepping rule: hold, increment, decrement, or a signed index. In index mode the address moves by a signed element offset after every element except the last of a frame. After the last element of a frame it moves by a separate signed frame offset. With these rules the same engine can copy linear blocks, transpose a matrix, or cut a sub-window out of a larger image.

Software programs the channel through a word-addressed register port and launches it with a start code. It learns of completion from a busy/done status field or from a one-cycle interrupt pulse.

The controller is a three-state machine:
- `ST_IDLE`: waiting for a launch. Launch with a non-zero element count goes to `ST_READ`. Launch with a zero element count completes at once and stays in `ST_IDLE`.
- `ST_READ`: read request held. The read acknowledge goes to `ST_WRITE`.
- `ST_WRITE`: write request held. The write acknowledge goes to `ST_IDLE` after the final element, or to `ST_READ` otherwise.

Top module: `frame_dma`

## Requirements
- R1: Register map, addressed by word index on `cfg_addr`:
  - 0 is control: start field [1:0], source mode [3:2], destination mode [5:4], size code [7:6], interrupt enable [8], busy [16], done [17]. Busy and done are read-only, and the start field reads back as 00.
  - 1 is count: frames in [31:16], elements in [15:0].
  - 2 is the source address and 3 is the destination address.
  - 4 is index: signed frame offset in [31:16], signed element offset in [15:0].
  - 5 is reload: element reload value in [15:0].
  - All registers read 0 after reset.
- R2: Only a control write whose start field is 01 launches a transfer. Any other start code leaves the channel idle and issues no memory request.
- R3: Each element is one read, with `rd_req` held until `rd_ack` and `rd_data` captured, followed by one write of that same word to the destination, with `wr_req` held until `wr_ack`. Read and write requests are never raised together.
- R4: Each completed read decrements the element count. When a frame's last element is read, the frame count decrements and the element count reloads from reload[15:0]. When the final element is read, the count register becomes 0.
- R5: A frame count of 0 or 1 runs exactly one frame.
- R6: Launching with an element count of 0 issues no memory request and sets done in the same cycle.
- R7: Mode 00 holds the address, 01 adds the element size, and 10 subtracts it. Size code 00 is 4 bytes, 01 is 2 bytes, 10 is 1 byte, and 11 is 4 bytes.
- R8: Mode 11 adds the sign-extended element offset after each element that is not last in its frame, and the sign-extended frame offset after the last one. This is enough for transpose and sub-window extraction.
- R9: Busy reads 1 from the launch until the final write is acknowledged. Done is cleared by a launch and set at completion.
- R10: With the interrupt enable set, `irq` pulses high for exactly one cycle at completion. With it clear, `irq` stays low.
- R11: Register writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write acknowledge |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The transfer is exercised with several patterns, each aimed at a different part of the engine:
- A linear 4-byte increment copy shows basic stepping and data forwarding.
- A 4-by-2 transpose with a negative destination frame offset shows whether the signed frame offset is applied only at frame ends. The visited destination order is compared against the hand-derived transposed order.
- A sub-window extraction with an indexed source and a 1-byte destination separates the per-element offset from the per-frame offset on the read side.
- A run with a first frame larger than the reload value, and a decrement/hold run with 2-byte elements, separate reload and size handling.
- Zero element count, a non-01 start code, a disabled interrupt, and register writes made while busy check that nothing moves when it should not.

The acknowledge latency is varied between runs so that request holding is exercised.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    localparam logic [1:0] MODE_HOLD = 2'b00;
    localparam logic [1:0] MODE_INC  = 2'b01;
    localparam logic [1:0] MODE_DEC  = 2'b10;
    localparam logic [1:0] MODE_IDX  = 2'b11;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_COUNT  = 3'd1;
    localparam logic [2:0] REG_SRC    = 3'd2;
    localparam logic [2:0] REG_DST    = 3'd3;
    localparam logic [2:0] REG_INDEX  = 3'd4;
    localparam logic [2:0] REG_RELOAD = 3'd5;

    localparam logic [1:0] START_CODE = 2'b01;

    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        case (code)
            2'b01:   elem_bytes = 3'd2;
            2'b10:   elem_bytes = 3'd1;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    mode,
    input  logic [1:0]    size_code,
    input  logic          frame_last,
    input  logic [IW-1:0] elem_off,
    input  logic [IW-1:0] frame_off,
    output logic [AW-1:0] nxt
);
    localparam int EXT = AW - IW;

    logic [IW-1:0] sel_off;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] size_ext;

    always_comb begin
        sel_off  = frame_last ? frame_off : elem_off;
        off_ext  = {{EXT{sel_off[IW-1]}}, sel_off};
        size_ext = AW'(elem_bytes(size_code));
        unique case (mode)
            MODE_HOLD: nxt = cur;
            MODE_INC:  nxt = cur + size_ext;
            MODE_DEC:  nxt = cur - size_ext;
            default:   nxt = cur + off_ext;
        endcase
    end

endmodule

// File: rtl/dma_count.sv
module dma_count #(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [2*CW-1:0] ld_val,
    input  logic            dec,
    input  logic [CW-1:0]   reload,
    output logic [CW-1:0]   elem,
    output logic [CW-1:0]   frame,
    output logic            last_elem,
    output logic            last_frame,
    output logic            zero
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem  <= '0;
            frame <= '0;
        end else if (ld_en) begin
            frame <= ld_val[2*CW-1:CW];
            elem  <= ld_val[CW-1:0];
        end else if (dec) begin
            if (elem == ONE) begin
                if (frame <= ONE) begin
                    frame <= '0;
                    elem  <= '0;
                end else begin
                    frame <= frame - ONE;
                    elem  <= reload;
                end
            end else begin
                elem <= elem - ONE;
            end
        end
    end

    assign last_elem  = (elem == ONE);
    assign last_frame = (frame <= ONE);
    assign zero       = (elem == '0);

    assert_elem_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld_en && !last_elem) |=> (elem == $past(elem) - ONE));

    assert_frame_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld_en && last_elem && !last_frame) |=>
            (frame == $past(frame) - ONE) && (elem == $past(reload)));

    assert_final_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld_en && last_elem && last_frame) |=> (elem == '0) && (frame == '0));

endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic zero_cnt,
    input  logic rd_ack,
    input  logic wr_ack,
    input  logic last_elem,
    input  logic last_frame,
    output logic rd_req,
    output logic wr_req,
    output logic busy,
    output logic cnt_dec,
    output logic addr_upd,
    output logic frame_end,
    output logic complete
);
    dma_state_e state_q, state_d;
    logic       fin_q;
    logic       end_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
            end_q <= 1'b0;
        end else if (state_q == ST_READ && rd_ack) begin
            end_q <= last_elem;
            fin_q <= last_elem && last_frame;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch && !zero_cnt) state_d = ST_READ;
            ST_READ:  if (rd_ack) state_d = ST_WRITE;
            ST_WRITE: if (wr_ack) state_d = fin_q ? ST_IDLE : ST_READ;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req    = 1'b0;
        wr_req    = 1'b0;
        busy      = 1'b1;
        cnt_dec   = 1'b0;
        addr_upd  = 1'b0;
        complete  = 1'b0;
        frame_end = end_q;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                complete = launch && zero_cnt;
            end
            ST_READ: begin
                rd_req  = 1'b1;
                cnt_dec = rd_ack;
            end
            ST_WRITE: begin
                wr_req   = 1'b1;
                addr_upd = wr_ack;
                complete = wr_ack && fin_q;
            end
            default: busy = 1'b0;
        endcase
    end

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> (wr_req && !rd_req));

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));

endmodule

// File: rtl/frame_dma.sv
module frame_dma
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [2:0]      cfg_addr,
    input  logic [2*CW-1:0] cfg_wdata,
    output logic [2*CW-1:0] cfg_rdata,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    input  logic            rd_ack,
    input  logic [2*CW-1:0] rd_data,
    output logic            wr_req,
    output logic [AW-1:0]   wr_addr,
    output logic [2*CW-1:0] wr_data,
    input  logic            wr_ack,
    output logic            irq
);
    localparam int RW = 2 * CW;

    logic [1:0]    src_mode, dst_mode, size_code;
    logic          irq_en;
    logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [RW-1:0] idx_q, reload_q, data_q;
    logic          done_q, irq_q;

    logic          busy, cnt_dec, addr_upd, frame_end, complete;
    logic          wr_ok, launch, irq_arm;
    logic [CW-1:0] elem, frame;
    logic          last_elem, last_frame, zero_cnt;

    assign wr_ok   = cfg_wr && !busy;
    assign launch  = wr_ok && (cfg_addr == REG_CTRL) && (cfg_wdata[1:0] == START_CODE);
    assign irq_arm = launch ? cfg_wdata[8] : irq_en;

    dma_count #(.CW(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (wr_ok && (cfg_addr == REG_COUNT)),
        .ld_val     (cfg_wdata),
        .dec        (cnt_dec),
        .reload     (reload_q[CW-1:0]),
        .elem       (elem),
        .frame      (frame),
        .last_elem  (last_elem),
        .last_frame (last_frame),
        .zero       (zero_cnt)
    );

    dma_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .zero_cnt   (zero_cnt),
        .rd_ack     (rd_ack),
        .wr_ack     (wr_ack),
        .last_elem  (last_elem),
        .last_frame (last_frame),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .busy       (busy),
        .cnt_dec    (cnt_dec),
        .addr_upd   (addr_upd),
        .frame_end  (frame_end),
        .complete   (complete)
    );

    dma_addr_step #(.AW(AW), .IW(CW)) u_src_step (
        .cur        (src_q),
        .mode       (src_mode),
        .size_code  (size_code),
        .frame_last (frame_end),
        .elem_off   (idx_q[CW-1:0]),
        .frame_off  (idx_q[RW-1:CW]),
        .nxt        (src_nxt)
    );

    dma_addr_step #(.AW(AW), .IW(CW)) u_dst_step (
        .cur        (dst_q),
        .mode       (dst_mode),
        .size_code  (size_code),
        .frame_last (frame_end),
        .elem_off   (idx_q[CW-1:0]),
        .frame_off  (idx_q[RW-1:CW]),
        .nxt        (dst_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_mode  <= MODE_HOLD;
            dst_mode  <= MODE_HOLD;
            size_code <= 2'b00;
            irq_en    <= 1'b0;
            idx_q     <= '0;
            reload_q  <= '0;
        end else if (wr_ok) begin
            case (cfg_addr)
                REG_CTRL: begin
                    src_mode  <= cfg_wdata[3:2];
                    dst_mode  <= cfg_wdata[5:4];
                    size_code <= cfg_wdata[7:6];
                    irq_en    <= cfg_wdata[8];
                end
                REG_INDEX:  idx_q    <= cfg_wdata;
                REG_RELOAD: reload_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (wr_ok && cfg_addr == REG_SRC)  src_q <= AW'(cfg_wdata);
            else if (addr_upd)                 src_q <= src_nxt;
            if (wr_ok && cfg_addr == REG_DST)  dst_q <= AW'(cfg_wdata);
            else if (addr_upd)                 dst_q <= dst_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (rd_req && rd_ack) data_q <= rd_data;
            if (complete)         done_q <= 1'b1;
            else if (launch)      done_q <= 1'b0;
            irq_q <= complete && irq_arm;
        end
    end

    always_comb begin
        case (cfg_addr)
            REG_CTRL:   cfg_rdata = RW'({done_q, busy, 7'd0, irq_en, size_code,
                                         dst_mode, src_mode, 2'b00});
            REG_COUNT:  cfg_rdata = {frame, elem};
            REG_SRC:    cfg_rdata = RW'(src_q);
            REG_DST:    cfg_rdata = RW'(dst_q);
            REG_INDEX:  cfg_rdata = idx_q;
            REG_RELOAD: cfg_rdata = reload_q;
            default:    cfg_rdata = '0;
        endcase
    end

    assign rd_addr = src_q;
    assign wr_addr = dst_q;
    assign wr_data = data_q;
    assign irq     = irq_q;

    assert_wr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> ($stable(wr_data) && $stable(wr_addr)));

    assert_dst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_upd && dst_mode == MODE_HOLD) |=> $stable(dst_q));

    assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q);

    assert_busy_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr && cfg_addr == REG_INDEX) |=> $stable(idx_q));

endmodule

// File: tb/frame_dma_test.sv
`timescale 1ns/1ps
module frame_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        rd_req, wr_req, irq;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, wr_ack = 1'b0;
    logic [31:0] rd_data = 32'd0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;
    int irq_cnt = 0;
    string cur_tag = "R3";
    logic [31:0] exp_ra[$];
    logic [31:0] exp_wa[$];
    logic [31:0] exp_wd[$];
    logic [31:0] obs_wa[$];

    always #10 clk = ~clk;

    frame_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1234_0000;
    endfunction

    function automatic logic [31:0] stp(input logic [31:0] a, input logic [1:0] m,
                                        input logic [1:0] sc, input bit last,
                                        input logic [15:0] fi, input logic [15:0] ei);
        int sz;
        logic [15:0] o;
        sz = (sc == 2'b01) ? 2 : (sc == 2'b10) ? 1 : 4;
        o = last ? fi : ei;
        case (m)
            2'b00:   return a;
            2'b01:   return a + 32'(sz);
            2'b10:   return a - 32'(sz);
            default: return a + {{16{o[15]}}, o};
        endcase
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // memory responder and per-clock comparison with the model queues
    initial begin
        int rc, wc;
        logic [31:0] e;
        rc = 0; wc = 0;
        forever begin
            @(negedge clk);
            rd_ack = 1'b0;
            wr_ack = 1'b0;
            if (rd_req && wr_req) check(1'b0, "R3 both requests", 32'd1, 32'd0);
            if (rd_req) begin
                if (rc >= lat) begin
                    rc = 0;
                    if (exp_ra.size() == 0) check(1'b0, "R2/R6 unexpected read", rd_addr, 32'd0);
                    else begin
                        e = exp_ra.pop_front();
                        check(rd_addr == e, {cur_tag, " read address"}, rd_addr, e);
                    end
                    rd_data = memf(rd_addr);
                    rd_ack = 1'b1;
                end else rc++;
            end
            if (wr_req) begin
                if (wc >= lat) begin
                    wc = 0;
                    obs_wa.push_back(wr_addr);
                    if (exp_wa.size() == 0) check(1'b0, "R2/R6 unexpected write", wr_addr, 32'd0);
                    else begin
                        e = exp_wa.pop_front();
                        check(wr_addr == e, {cur_tag, " write address"}, wr_addr, e);
                        e = exp_wd.pop_front();
                        check(wr_data == e, "R3 write data", wr_data, e);
                    end
                    wr_ack = 1'b1;
                end else wc++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic run(input string tag, input logic [1:0] sm, input logic [1:0] dm,
                       input logic [1:0] sc, input bit ien,
                       input logic [31:0] s0, input logic [31:0] d0,
                       input logic [15:0] fc, input logic [15:0] ec, input logic [15:0] rl,
                       input logic [15:0] fi, input logic [15:0] ei,
                       input int lat_i, input bit poke);
        logic [31:0] s, d, v;
        int frames, n;
        cur_tag = tag;
        lat = lat_i;
        irq_cnt = 0;
        obs_wa.delete();
        s = s0; d = d0;
        frames = (fc <= 1) ? 1 : int'(fc);
        if (ec != 0) begin
            for (int f = 0; f < frames; f++) begin
                n = (f == 0) ? int'(ec) : int'(rl);
                for (int k = 0; k < n; k++) begin
                    exp_ra.push_back(s);
                    exp_wa.push_back(d);
                    exp_wd.push_back(memf(s));
                    s = stp(s, sm, sc, k == n - 1, fi, ei);
                    d = stp(d, dm, sc, k == n - 1, fi, ei);
                end
            end
        end
        cfg_write(3'd1, {fc, ec});
        cfg_write(3'd2, s0);
        cfg_write(3'd3, d0);
        cfg_write(3'd4, {fi, ei});
        cfg_write(3'd5, {16'd0, rl});
        cfg_write(3'd0, {23'd0, ien, sc, dm, sm, 2'b01});
        cfg_read(3'd0, v);
        if (ec != 0) begin
            check(v[16] == 1'b1, "R9 busy after launch", {31'd0, v[16]}, 32'd1);
            check(v[17] == 1'b0, "R9 done cleared by launch", {31'd0, v[17]}, 32'd0);
        end else begin
            check(v[17] == 1'b1 && v[16] == 1'b0, "R6 zero count done at once", v, 32'h0002_0000);
        end
        if (poke) begin
            cfg_write(3'd2, 32'hDEAD_0000);
            cfg_write(3'd1, 32'h0009_0009);
        end
        for (int i = 0; i < 3000; i++) begin
            cfg_read(3'd0, v);
            if (v[17]) break;
        end
        repeat (3) @(negedge clk);
        cfg_read(3'd0, v);
        check(v[17:16] == 2'b10, "R9 done set and busy low", {30'd0, v[17:16]}, 32'd2);
        check(v[8:2] == {ien, sc, dm, sm} && v[1:0] == 2'b00, "R1 control readback",
              v, {23'd0, ien, sc, dm, sm, 2'b00});
        check(exp_ra.size() == 0 && exp_wa.size() == 0, "R3 every element moved",
              32'(exp_wa.size()), 32'd0);
        if (ec != 0) begin
            cfg_read(3'd1, v);
            check(v == 32'd0, "R4 count reads zero at end", v, 32'd0);
        end
        cfg_read(3'd2, v);
        check(v == s, {tag, " final source address"}, v, s);
        cfg_read(3'd3, v);
        check(v == d, {tag, " final destination address"}, v, d);
        check(irq_cnt == (ien ? 1 : 0), "R10 interrupt pulse count", 32'(irq_cnt), ien ? 32'd1 : 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] tr[8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int r = 0; r < 6; r++) begin
            cfg_read(3'(r), v);
            check(v == 32'd0, "R1 register reset value", v, 32'd0);
        end
        check(!rd_req && !wr_req && !irq, "R1 outputs idle after reset",
              {29'd0, rd_req, wr_req, irq}, 32'd0);

        // R2: wrong start code does not launch
        cfg_write(3'd1, 32'h0001_0004);
        cfg_write(3'd0, 32'h0000_0016);
        repeat (4) @(negedge clk);
        cfg_read(3'd0, v);
        check(v[16] == 1'b0, "R2 start code 10 ignored", {31'd0, v[16]}, 32'd0);

        // R7: linear 4-byte copy, with writes while busy (R11)
        run("R7", 2'b01, 2'b01, 2'b00, 1'b1, 32'h0000_1000, 32'h0008_0000,
            16'd1, 16'd4, 16'd4, 16'd0, 16'd0, 2, 1'b1);
        check(1'b1, "R11 busy writes ignored (addresses checked above)", 32'd0, 32'd0);

        // R8: 4x2 transpose, 2-byte elements, destination indexed
        run("R8", 2'b01, 2'b11, 2'b01, 1'b1, 32'h0200_0000, 32'h8000_0000,
            16'd4, 16'd2, 16'd2, 16'hFFFA, 16'd8, 0, 1'b0);
        tr = '{0, 8, 2, 10, 4, 12, 6, 14};
        for (int k = 0; k < 8; k++) begin
            v = (k < obs_wa.size()) ? obs_wa[k] : 32'hFFFF_FFFF;
            check(v == 32'h8000_0000 + tr[k], "R8 transpose destination order",
                  v, 32'h8000_0000 + tr[k]);
        end

        // R8: sub-window 2 rows of 4 from width-8 image, 1-byte elements
        run("R8", 2'b11, 2'b01, 2'b10, 1'b0, 32'h0000_4000, 32'h0000_9000,
            16'd2, 16'd4, 16'd4, 16'd5, 16'd1, 1, 1'b0);

        // R4: first frame larger than reload
        run("R4", 2'b01, 2'b11, 2'b00, 1'b1, 32'h0000_0100, 32'h0000_0200,
            16'd3, 16'd3, 16'd2, 16'h0010, 16'h0004, 1, 1'b0);

        // R5: frame count 0 is one frame; R7 decrement and hold
        run("R5", 2'b10, 2'b00, 2'b01, 1'b1, 32'h0000_0100, 32'h0000_2000,
            16'd0, 16'd3, 16'd7, 16'd0, 16'd0, 0, 1'b0);

        // R6: element count zero
        run("R6", 2'b01, 2'b01, 2'b00, 1'b1, 32'h0000_0300, 32'h0000_0400,
            16'd2, 16'd0, 16'd2, 16'd0, 16'd0, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule